// File: doc/BRIEF.md
# Page ECC syndrome unit

The unit watches bytes as they pass through a card data port and builds a single-error-correcting parity code over a 512-byte page. The page is split into two 256-byte halves, and each half gets its own 24-bit code. A code holds 16 line-parity bits, taken over the byte index, and 6 column-parity bits, taken over the bit position within a byte. The two top bits are spare and always read as 1.

Software uses the unit in one of two ways. When writing a page, software reads back the two codes and stores them beside the data. When reading a page back, software writes the stored codes into the unit and then reads one word that holds a 16-bit syndrome for each half. A syndrome gives the failing byte index, the failing bit index and a status flag. Software then corrects the data itself.

All result traffic goes through the shared data register while the access-select input is high. A data-register read made while accumulation is also enabled flushes the unit before a new page. This clears the accumulators, the byte counter, the read pointer and the stored codes.

Top module: `ecc_page_syndrome`

## Requirements
- R1: After reset, with access select high and accumulation off, `rdata_o` reads 0x00C00000. This is the code of an empty half: all parity bits 0 and spare bits [23:22] = 11.
- R2: A read strobe taken while both access select and accumulation enable are high is a flush. After a flush, the unit reads as in R1. The read pointer returns to the first half, and any stored codes are discarded.
- R3: A byte is accumulated only in a cycle with `ecc_en_i` and `byte_vld_i` both high. Bytes offered after the 512th byte since the last flush are ignored.
- R4: Code layout, for byte index i and bit position b within a byte:
  - Bit 2k is the XOR of the parities of all bytes whose index bit k is 0, and bit 2k+1 is the same over bytes whose index bit k is 1 (k = 0..7).
  - Bit 16+2j is the XOR of all data bits whose position bit j is 0, and bit 17+2j is the same over positions whose bit j is 1 (j = 0..2).
  - Bits [23:22] are 11, and `rdata_o[31:24]` is 0.
- R5: Bytes 0..255 after a flush form the first-half code, and bytes 256..511 form the second-half code.
- R6: Before stored codes are loaded, successive reads (accumulation off) return the first-half code, then the second, then the first again. A read strobe advances the pointer.
- R7: The first data write with access select high loads the stored first-half code, and the second loads the second-half code. Further writes are ignored until the next flush. Once both are loaded, `rdata_o` returns {second-half syndrome, first-half syndrome}.
- R8: A syndrome where stored and computed codes agree reads 0x1000 (flag 0x10, byte and bit fields 0).
- R9: A single flipped data bit at index i, position b of a half gives the syndrome {0x20 | b, i}.
- R10: When stored and computed codes differ in exactly one bit, spare bits included, the syndrome is 0x20FF. The fault is in the code itself. This value coincides with a data fault at byte 255, bit 0.
- R11: Any other difference gives 0x4000, the uncorrectable flag with byte and bit fields 0.
- R12: While access select is low, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en_i | input | 1 | Accumulation enable control bit |
| ecc_sel_i | input | 1 | Routes data register accesses to the unit |
| byte_vld_i | input | 1 | A data byte passes through the card port this cycle |
| byte_i | input | 8 | The passing data byte |
| rd_i | input | 1 | Data register read strobe |
| wr_i | input | 1 | Data register write strobe |
| wdata_i | input | 24 | Stored code written by software |
| rdata_o | output | 32 | Result word: a code, or two syndromes |

## Verification
The assertions check several properties on every cycle:
- The output gating by access select.
- The empty code seen right after a flush.
- The byte counter's ceiling, and that it holds while accumulation is off.
- The spare-bit pattern of code reads.
- That each syndrome carries exactly one flag, and that the no-error and uncorrectable flags come with zero position fields.

Only the bench's scenarios can show the following:
- That codes match the line and column parity definitions over real data.
- That the halves split at byte 256.
- That the read pointer alternates between halves.
- That each injected data or parity fault decodes to the correct byte and bit.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int BYTE_W  = 8;
    localparam int COLP_W  = 6;
    localparam int SPARE_W = 2;
    localparam int SYN_W   = 16;

    localparam logic [7:0] FLAG_CLEAN = 8'h10;
    localparam logic [7:0] FLAG_FIX   = 8'h20;
    localparam logic [7:0] FLAG_BAD   = 8'h40;
    localparam logic [7:0] POS_IN_CODE = 8'hFF;

    typedef struct packed {
        logic [7:0] flags;
        logic [7:0] pos;
    } syn_t;

    // mask of bit positions b (0..7) whose bit j equals want
    function automatic logic [7:0] bit_group_mask(input int j, input logic want);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = (((b >> j) & 1) == int'(want));
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc #(
    parameter int IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  take_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [7:0]            byte_i,
    output logic [2*IDX_W+7:0]    code_o
);
    localparam int LINE_W = 2 * IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0] lp_zero;
        logic [IDX_W-1:0] lp_one;
        logic [7:0]       col;
    } acc_t;

    acc_t acc_d, acc_q;
    logic byte_par;

    always_comb begin
        acc_d    = acc_q;
        byte_par = ^byte_i;
        if (clr_i) begin
            acc_d = '0;
        end else if (take_i) begin
            for (int k = 0; k < IDX_W; k++) begin
                if (idx_i[k]) acc_d.lp_one[k]  = acc_q.lp_one[k] ^ byte_par;
                else          acc_d.lp_zero[k] = acc_q.lp_zero[k] ^ byte_par;
            end
            acc_d.col = acc_q.col ^ byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    for (genvar k = 0; k < IDX_W; k++) begin : g_line
        assign code_o[2*k]   = acc_q.lp_zero[k];
        assign code_o[2*k+1] = acc_q.lp_one[k];
    end

    for (genvar j = 0; j < 3; j++) begin : g_col
        assign code_o[LINE_W+2*j]   = ^(acc_q.col & ecc_pkg::bit_group_mask(j, 1'b0));
        assign code_o[LINE_W+2*j+1] = ^(acc_q.col & ecc_pkg::bit_group_mask(j, 1'b1));
    end

    assign code_o[LINE_W+7:LINE_W+6] = 2'b11;

endmodule

// File: rtl/ecc_syn_decode.sv
module ecc_syn_decode #(
    parameter int IDX_W = 8
) (
    input  logic [2*IDX_W+7:0] stored_i,
    input  logic [2*IDX_W+7:0] calc_i,
    output logic [15:0]        syn_o
);
    localparam int CODE_W = 2 * IDX_W + 8;
    localparam int NPAIR  = IDX_W + 3;

    logic [CODE_W-1:0] diff;
    logic [NPAIR-1:0]  pair_split;
    logic [NPAIR-1:0]  odd_side;
    logic [IDX_W-1:0]  bad_idx;
    logic [2:0]        bad_bit;
    int                ones;
    ecc_pkg::syn_t     syn;

    assign diff = stored_i ^ calc_i;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_split[p] = diff[2*p] ^ diff[2*p+1];
        assign odd_side[p]   = diff[2*p+1];
    end

    assign bad_idx = odd_side[IDX_W-1:0];
    assign bad_bit = odd_side[NPAIR-1:IDX_W];

    always_comb begin
        ones = $countones(diff);
        syn  = '0;
        if (ones == 0) begin
            syn.flags = ecc_pkg::FLAG_CLEAN;
        end else if (ones == 1) begin
            syn.flags = ecc_pkg::FLAG_FIX;
            syn.pos   = ecc_pkg::POS_IN_CODE;
        end else if ((&pair_split) && (diff[CODE_W-1:CODE_W-2] == 2'b00)) begin
            syn.flags = ecc_pkg::FLAG_FIX | {5'b0, bad_bit};
            syn.pos   = 8'(bad_idx);
        end else begin
            syn.flags = ecc_pkg::FLAG_BAD;
        end
    end

    assign syn_o = syn;

endmodule

// File: rtl/ecc_page_syndrome.sv
module ecc_page_syndrome #(
    parameter int HALF_BYTES = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ecc_en_i,
    input  logic                              ecc_sel_i,
    input  logic                              byte_vld_i,
    input  logic [7:0]                        byte_i,
    input  logic                              rd_i,
    input  logic                              wr_i,
    input  logic [2*$clog2(HALF_BYTES)+7:0]   wdata_i,
    output logic [31:0]                       rdata_o
);
    localparam int IDX_W      = $clog2(HALF_BYTES);
    localparam int CODE_W     = 2 * IDX_W + 8;
    localparam int CNT_W      = IDX_W + 2;
    localparam int PAGE_BYTES = 2 * HALF_BYTES;

    typedef struct packed {
        logic [CNT_W-1:0]       cnt;
        logic                   ptr;
        logic [1:0]             loaded;
        logic [1:0][CODE_W-1:0] stored;
    } st_t;

    st_t st_d, st_q;

    logic                   flush, take, pop, load, syn_mode;
    logic [1:0]             take_half;
    logic [1:0][CODE_W-1:0] calc;
    logic [1:0][15:0]       syn;
    logic [CNT_W-1:0]       cnt_w;

    assign flush    = ecc_sel_i & rd_i & ecc_en_i;
    assign syn_mode = (st_q.loaded == 2'd2);
    assign take     = ecc_en_i & byte_vld_i & ~flush
                    & (st_q.cnt < CNT_W'(PAGE_BYTES));
    assign pop      = ecc_sel_i & rd_i & ~ecc_en_i & ~syn_mode;
    assign load     = ecc_sel_i & wr_i & ~flush & ~syn_mode;
    assign cnt_w    = st_q.cnt;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign take_half[h] = take & (st_q.cnt[IDX_W] == 1'(h));

        ecc_half_acc #(.IDX_W(IDX_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (flush),
            .take_i (take_half[h]),
            .idx_i  (st_q.cnt[IDX_W-1:0]),
            .byte_i (byte_i),
            .code_o (calc[h])
        );

        ecc_syn_decode #(.IDX_W(IDX_W)) u_dec (
            .stored_i (st_q.stored[h]),
            .calc_i   (calc[h]),
            .syn_o    (syn[h])
        );
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (take) st_d.cnt = st_q.cnt + 1'b1;
            if (pop)  st_d.ptr = ~st_q.ptr;
            if (load) begin
                st_d.stored[st_q.loaded[0]] = wdata_i;
                st_d.loaded = st_q.loaded + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!ecc_sel_i)    rdata_o = '0;
        else if (syn_mode) rdata_o = {syn[1], syn[0]};
        else               rdata_o = 32'(calc[st_q.ptr]);
    end

endmodule

// File: rtl/ecc_page_syndrome_chk.sv
module ecc_page_syndrome_chk #(
    parameter int HALF_BYTES = 256
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ecc_en_i,
    input logic                           ecc_sel_i,
    input logic                           rd_i,
    input logic [31:0]                    rdata_o,
    input logic                           syn_mode,
    input logic [$clog2(HALF_BYTES)+1:0]  byte_cnt
);
    localparam int IDX_W  = $clog2(HALF_BYTES);
    localparam int CODE_W = 2 * IDX_W + 8;
    localparam int CNT_W  = IDX_W + 2;
    localparam logic [31:0] EMPTY = 32'(2'b11) << (CODE_W - 2);

    assert_sel_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_sel_i |-> rdata_o == 32'd0);

    assert_flush_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_sel_i && rd_i && ecc_en_i) |=> (!ecc_sel_i || rdata_o == EMPTY));

    assert_cnt_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(2 * HALF_BYTES));

    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en_i |=> $stable(byte_cnt));

    assert_spare_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_sel_i && !syn_mode) |->
        (rdata_o[31:CODE_W] == '0 && rdata_o[CODE_W-1 -: 2] == 2'b11));

    assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_sel_i && syn_mode) |->
        ($countones(rdata_o[14:12]) == 1 && $countones(rdata_o[30:28]) == 1));

    assert_clean_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_sel_i && syn_mode && rdata_o[15:8] == 8'h10) |-> rdata_o[7:0] == 8'h00);

    assert_bad_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_sel_i && syn_mode && rdata_o[14]) |-> rdata_o[15:0] == 16'h4000);

endmodule

bind ecc_page_syndrome ecc_page_syndrome_chk #(.HALF_BYTES(HALF_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_en_i  (ecc_en_i),
    .ecc_sel_i (ecc_sel_i),
    .rd_i      (rd_i),
    .rdata_o   (rdata_o),
    .syn_mode  (syn_mode),
    .byte_cnt  (cnt_w)
);

// File: tb/ecc_page_syndrome_test.sv
module ecc_page_syndrome_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0, ecc_sel = 1'b0, vld = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0]  byt = 8'h00;
    logic [23:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] pg [512];

    always #5 clk = ~clk;

    ecc_page_syndrome uut (
        .clk(clk), .rst_n(rst_n), .ecc_en_i(ecc_en), .ecc_sel_i(ecc_sel),
        .byte_vld_i(vld), .byte_i(byt), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model_code(input int base);
        logic [23:0] c = '0;
        for (int i = 0; i < 256; i++) begin
            logic p = ^pg[base+i];
            for (int k = 0; k < 8; k++) begin
                if (((i >> k) & 1) == 1) c[2*k+1] ^= p;
                else                     c[2*k]   ^= p;
            end
            for (int b = 0; b < 8; b++) begin
                if (pg[base+i][b]) begin
                    for (int j = 0; j < 3; j++) begin
                        if (((b >> j) & 1) == 1) c[16+2*j+1] ^= 1'b1;
                        else                     c[16+2*j]   ^= 1'b1;
                    end
                end
            end
        end
        c[23:22] = 2'b11;
        return c;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 512; i++) begin
            if (seed == 0)      pg[i] = 8'h00;
            else if (seed == 1) pg[i] = 8'hFF;
            else if (seed == 2) pg[i] = (i == 300) ? 8'h40 : 8'h00;
            else                pg[i] = 8'((i * 37) + (seed * 11) + 5 + (i >> 3));
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic flush;
        ecc_en = 1'b1; ecc_sel = 1'b1; rd = 1'b1;
        tick();
        rd = 1'b0; ecc_sel = 1'b0;
    endtask

    // gaps: idle cycles with vld low, and cycles with enable low, carry junk (R3)
    task automatic stream(input int n, input bit gaps);
        ecc_en = 1'b1; ecc_sel = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 7 == 3)) begin
                vld = 1'b0; byt = 8'h5A; tick();
                ecc_en = 1'b0; vld = 1'b1; byt = 8'hC3; tick();
                ecc_en = 1'b1;
            end
            vld = 1'b1;
            byt = (i < 512) ? pg[i] : 8'(i * 13 + 1);
            tick();
        end
        vld = 1'b0;
        ecc_en = 1'b0;
    endtask

    task automatic rd_pulse;
        rd = 1'b1; tick(); rd = 1'b0;
    endtask

    task automatic wr_word(input logic [23:0] w);
        wr = 1'b1; wdata = w; tick(); wr = 1'b0;
    endtask

    task automatic see_result;
        ecc_en = 1'b0; ecc_sel = 1'b1; #1;
    endtask

    // stream pg (possibly corrupted) and load stored codes c0/c1; return syndrome word
    task automatic syn_run(input logic [23:0] c0, input logic [23:0] c1,
                           output logic [31:0] got);
        flush();
        stream(512, 1'b0);
        see_result();
        wr_word(c0);
        wr_word(c1);
        #1 got = rdata;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [23:0] c0, c1, e0, e1;
        logic [31:0] got;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R12 sel low after reset", rdata, 32'h0);
        see_result();
        chk("R1 empty code after reset", rdata, 32'h00C00000);
        rd_pulse(); #1;
        chk("R1 empty code second half", rdata, 32'h00C00000);
        ecc_sel = 1'b0;

        // code generation over several patterns (R3 R4 R5 R6)
        for (int s = 0; s < 7; s++) begin
            fill(s);
            flush();
            #1 begin ecc_sel = 1'b1; #1; end
            chk("R2 flush gives empty code", rdata, 32'h00C00000);
            ecc_sel = 1'b0;
            stream((s == 6) ? 540 : 512, s >= 4);
            e0 = model_code(0);
            e1 = model_code(256);
            #1 chk("R12 sel low hides result", rdata, 32'h0);
            see_result();
            chk("R4 R5 first half code", rdata, {8'h0, e0});
            rd_pulse(); #1;
            chk("R5 R6 second half code", rdata, {8'h0, e1});
            rd_pulse(); #1;
            chk("R6 pointer wraps to first", rdata, {8'h0, e0});
            if (s == 6) chk("R3 bytes past page ignored", rdata, {8'h0, e0});
            ecc_sel = 1'b0;
        end

        // no error, and writes beyond two ignored (R7 R8)
        fill(9);
        c0 = model_code(0); c1 = model_code(256);
        syn_run(c0, c1, got);
        chk("R8 clean syndromes", got, 32'h10001000);
        wr_word(24'h123456); #1;
        chk("R7 third write ignored", rdata, 32'h10001000);
        rd_pulse(); #1;
        chk("R7 syndrome read does not advance", rdata, 32'h10001000);
        // flush discards stored codes and pointer (R2)
        flush();
        stream(512, 1'b0);
        see_result();
        chk("R2 flush returns to code reads", rdata, {8'h0, c0});
        ecc_sel = 1'b0;

        // correctable data faults (R9)
        for (int n = 0; n < 43; n++) begin
            int pos, bt;
            if (n == 40)      begin pos = 0;   bt = 0; end
            else if (n == 41) begin pos = 511; bt = 7; end
            else if (n == 42) begin pos = 256; bt = 0; end
            else begin pos = (n * 53 + 7) % 512; bt = n % 8; end
            fill(n + 3);
            c0 = model_code(0); c1 = model_code(256);
            pg[pos][bt] = ~pg[pos][bt];
            syn_run(c0, c1, got);
            if (pos < 256)
                chk("R9 correctable in first half", got,
                    {16'h1000, 8'h20 | 8'(bt), 8'(pos)});
            else
                chk("R9 correctable in second half", got,
                    {8'h20 | 8'(bt), 8'(pos - 256), 16'h1000});
        end

        // single bit fault inside a stored code, spares included (R10)
        for (int b = 0; b < 24; b++) begin
            fill(b + 50);
            c0 = model_code(0); c1 = model_code(256);
            if (b % 2 == 0) begin
                c0[b] = ~c0[b];
                syn_run(c0, c1, got);
                chk("R10 code fault first half", got, 32'h100020FF);
            end else begin
                c1[b] = ~c1[b];
                syn_run(c0, c1, got);
                chk("R10 code fault second half", got, 32'h20FF1000);
            end
        end

        // uncorrectable (R11)
        for (int n = 0; n < 4; n++) begin
            fill(n + 80);
            c0 = model_code(0); c1 = model_code(256);
            if (n == 0) begin pg[10][1] = ~pg[10][1]; pg[77][5] = ~pg[77][5]; end
            if (n == 1) begin pg[300][0] = ~pg[300][0]; pg[301][0] = ~pg[301][0]; end
            if (n == 2) begin pg[5][2] = ~pg[5][2]; pg[5][6] = ~pg[5][6]; end
            if (n == 3) begin c0 = ~c0; end
            syn_run(c0, c1, got);
            if (n == 1) chk("R11 double fault second half", got, 32'h40001000);
            else        chk("R11 double fault first half", got, 32'h10004000);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule